// File: doc/BRIEF.md
# Compare-Match Timer Counter Channel

A single 16-bit up-counting timer channel that produces compare events and a waveform output. Each system clock cycle the channel either advances or holds. It advances only when two things are true: the clock source it has selected gives a one-cycle tick, and the channel's own run enable is on. The tick can come from one of four divided rates of the system clock, from an already-synchronous slow tick input, or from an external pin. The external pin is synchronized, and the channel counts its rising edges.

The counter can run freely, wrapping from 0xFFFF to 0. It can also reload to zero after reaching the compare-C value, which makes a periodic timer. If stop-on-C is also set, a compare-C event turns the run enable off, which makes a one-shot timer. Compare A and compare C each set, clear or toggle the waveform output. Feeding that output into the external pin of a second channel cascades the two counters into a wider count.

Compare-C events set a sticky status flag. The flag raises the interrupt when its mask bit is on. A block-level sync input zeroes the counter.

Top module: `cmt_channel`

Register addresses (`addr_i`): 0 command (write only; bit0 run on, bit1 run off, bit2 restart), 1 mode (read/write; bits[2:0] source, bit3 reload-on-C, bit4 stop-on-C, bits[6:5] compare-A action, bits[8:7] compare-C action; action codes 0 none, 1 set, 2 clear, 3 toggle), 2 count (read), 3 compare A, 4 compare C, 5 status (bit0 compare-C flag, cleared by a read), 6 mask set (write bit0), 7 mask clear (write bit0). The source codes are 0..3 for the system clock divided by 2, 8, 32 and 128, 4 for the slow tick, 5 for the external pin, and 6..7 for no source.

## Requirements
- R1: After reset the count, mode, status, mask, waveform output and interrupt are all zero, and the run enable is off, so source ticks leave the count unchanged.
- R2: A command write with bit0 turns the run enable on and a write with bit1 turns it off; bit1 wins when both are set. Bit2 zeroes the count whether or not the channel runs. While the run enable is off, the count holds.
- R3: With reload-on-C off, the count advances by one per tick and wraps from 0xFFFF to 0.
- R4: With reload-on-C on, a tick that arrives while the count equals compare C is a compare-C event, and it loads zero, so the period is compare C + 1 ticks.
- R5: With stop-on-C on, a compare-C event turns the run enable off, and later ticks are ignored until a new run-on command is written.
- R6: A compare-C event sets the status flag. The flag holds until status is read, and the read clears it one cycle later. A compare-C event in the same cycle as the read leaves the flag set.
- R7: The interrupt output is high exactly when the status flag and the mask bit are both set. Writing bit0 to address 6 sets the mask and writing bit0 to address 7 clears it.
- R8: The compare-A and compare-C actions update the waveform output on the tick that leaves the matching count. When both compares match on one tick, the compare-C action wins.
- R9: Source codes 0 and 1 advance the count exactly 64 and 16 times per 128 system cycles, and source code 6 never advances it.
- R10: With source code 5, each rising edge on the external pin advances the count once, however long the pin stays high. A neighbour channel's waveform output can drive this pin.
- R11: The sync input zeroes the count on the next clock edge without changing the run enable.
- R12: A new compare-C value takes effect at once. A count already above it passes without a compare event until it comes around again.
- R13: Compare A, compare C and the mode register read back what was written, and the count reads back its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears status on address 5) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| slow_tick_i | input | 1 | Synchronous slow-rate tick, one cycle wide |
| ext_clk_i | input | 1 | Asynchronous external count input |
| sync_i | input | 1 | Block-level counter reset |
| wave_o | output | 1 | Compare-driven waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes take effect at the first clock edge after the strobe. A slow tick that is high at a rising edge is visible in the count, the status and the waveform output at the next falling edge. The status clear from a read also lands one edge later, but the read data shows the flag as it was before the clear. The external pin goes through two synchronizer flops and an edge flop, so a rising edge moves the count on the third clock edge. The bench therefore drives every input at a falling edge and samples results one falling edge later. Divided rates are checked as count differences over a 128-cycle window, so the prescaler phase does not affect the result, and the waveform duty is measured over a whole number of its periods.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned SRC_W  = 3;

  localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPC = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;
  localparam logic [ADDR_W-1:0] A_IDIS = 3'd7;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } wave_act_e;

  typedef struct packed {
    wave_act_e        act_c;
    wave_act_e        act_a;
    logic             stop_c;
    logic             auto_rst;
    logic [SRC_W-1:0] src;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/cmt_tick_src.sv
module cmt_tick_src
  import cmt_pkg::*;
#(
  parameter int unsigned PRE_STAGES  = 4,
  parameter int unsigned PRE_STEP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] sel_i,
  input  logic             slow_tick_i,
  input  logic             ext_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = 1 + (PRE_STAGES - 1) * PRE_STEP;

  logic [PRE_W-1:0]       pre_q;
  logic [PRE_STAGES-1:0]  div_tick;
  logic [SYNC_STAGES:0]   ext_sh_q;
  logic                   ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // rate i ticks once every 2^(1+i*PRE_STEP) cycles
  for (genvar i = 0; i < PRE_STAGES; i++) begin : g_div
    localparam int unsigned W = 1 + i * PRE_STEP;
    assign div_tick[i] = &pre_q[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sh_q <= '0;
    else         ext_sh_q <= {ext_sh_q[SYNC_STAGES-1:0], ext_i};
  end
  assign ext_tick = ext_sh_q[SYNC_STAGES-1] & ~ext_sh_q[SYNC_STAGES];

  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < int'(PRE_STAGES); i++)
      if (sel_i == SRC_W'(i)) tick_o = div_tick[i];
    if (sel_i == SRC_W'(PRE_STAGES))     tick_o = slow_tick_i;
    if (sel_i == SRC_W'(PRE_STAGES + 1)) tick_o = ext_tick;
  end
endmodule

// File: rtl/cmt_core.sv
module cmt_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_tick_i,
  input  logic             en_cmd_i,
  input  logic             dis_cmd_i,
  input  logic             trg_cmd_i,
  input  logic             sync_i,
  input  logic             auto_rst_i,
  input  logic             stop_c_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_c_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             tick_o,
  output logic             match_a_o,
  output logic             match_c_o
);
  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             clear;

  assign clear     = trg_cmd_i | sync_i;
  assign tick_o    = src_tick_i & run_q;
  assign match_c_o = tick_o & ~clear & (count_q == cmp_c_i);
  assign match_a_o = tick_o & ~clear & (count_q == cmp_a_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      count_q <= '0;
    else if (clear)                   count_q <= '0;
    else if (match_c_o && auto_rst_i) count_q <= '0;
    else if (tick_o)                  count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_q <= 1'b0;
    else if (dis_cmd_i)             run_q <= 1'b0;
    else if (en_cmd_i)              run_q <= 1'b1;
    else if (match_c_o && stop_c_i) run_q <= 1'b0;
  end

  assign count_o = count_q;
  assign run_o   = run_q;
endmodule

// File: rtl/cmt_wave.sv
module cmt_wave
  import cmt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      match_a_i,
  input  logic      match_c_i,
  input  wave_act_e act_a_i,
  input  wave_act_e act_c_i,
  output logic      wave_o
);
  logic wave_q;

  function automatic logic apply(input wave_act_e act, input logic cur);
    case (act)
      ACT_SET: apply = 1'b1;
      ACT_CLR: apply = 1'b0;
      ACT_TGL: apply = ~cur;
      default: apply = cur;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wave_q <= 1'b0;
    else if (match_c_i) wave_q <= apply(act_c_i, wave_q);
    else if (match_a_i) wave_q <= apply(act_a_i, wave_q);
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_STAGES  = 4,
  parameter int unsigned PRE_STEP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              slow_tick_i,
  input  logic              ext_clk_i,
  input  logic              sync_i,
  output logic              wave_o,
  output logic              irq_o
);
  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_c_q;
  logic             cpcs_q, mask_q;

  logic             cmd_wr, en_cmd, dis_cmd, trg_cmd, stat_rd;
  logic             src_tick, tick, run, match_a, match_c;
  logic [CNT_W-1:0] count;
  logic             auto_rst, stop_c;
  wave_act_e        act_c;

  assign cmd_wr   = wr_en_i & (addr_i == A_CMD);
  assign en_cmd   = cmd_wr & wdata_i[0];
  assign dis_cmd  = cmd_wr & wdata_i[1];
  assign trg_cmd  = cmd_wr & wdata_i[2];
  assign stat_rd  = rd_en_i & (addr_i == A_STAT);
  assign auto_rst = mode_q.auto_rst;
  assign stop_c   = mode_q.stop_c;
  assign act_c    = mode_q.act_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      cmp_a_q <= '0;
      cmp_c_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MODE:  mode_q  <= mode_t'(wdata_i[MODE_W-1:0]);
        A_CMPA:  cmp_a_q <= wdata_i;
        A_CMPC:  cmp_c_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // set beats the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cpcs_q <= 1'b0;
    else if (match_c) cpcs_q <= 1'b1;
    else if (stat_rd) cpcs_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= 1'b0;
    else if (wr_en_i && addr_i == A_IEN  && wdata_i[0]) mask_q <= 1'b1;
    else if (wr_en_i && addr_i == A_IDIS && wdata_i[0]) mask_q <= 1'b0;
  end

  assign irq_o = cpcs_q & mask_q;

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = CNT_W'(mode_q);
      A_CNT:   rdata_o = count;
      A_CMPA:  rdata_o = cmp_a_q;
      A_CMPC:  rdata_o = cmp_c_q;
      A_STAT:  rdata_o = CNT_W'(cpcs_q);
      default: rdata_o = '0;
    endcase
  end

  cmt_tick_src #(
    .PRE_STAGES (PRE_STAGES),
    .PRE_STEP   (PRE_STEP),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (mode_q.src),
    .slow_tick_i(slow_tick_i),
    .ext_i      (ext_clk_i),
    .tick_o     (src_tick)
  );

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_tick_i(src_tick),
    .en_cmd_i  (en_cmd),
    .dis_cmd_i (dis_cmd),
    .trg_cmd_i (trg_cmd),
    .sync_i    (sync_i),
    .auto_rst_i(auto_rst),
    .stop_c_i  (stop_c),
    .cmp_a_i   (cmp_a_q),
    .cmp_c_i   (cmp_c_q),
    .count_o   (count),
    .run_o     (run),
    .tick_o    (tick),
    .match_a_o (match_a),
    .match_c_o (match_c)
  );

  cmt_wave u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_a_i(match_a),
    .match_c_i(match_c),
    .act_a_i  (mode_q.act_a),
    .act_c_i  (act_c),
    .wave_o   (wave_o)
  );
endmodule

// File: rtl/cmt_chk.sv
module cmt_chk
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             trg_i,
  input logic             en_cmd_i,
  input logic             run_i,
  input logic             tick_i,
  input logic             match_c_i,
  input logic             auto_rst_i,
  input logic             stop_c_i,
  input logic [1:0]       act_c_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] cmp_c_i,
  input logic             stat_rd_i,
  input logic             cpcs_i,
  input logic             wave_i
);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sync_i && !trg_i) |=> $stable(count_i));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && auto_rst_i && count_i == cmp_c_i && !sync_i && !trg_i) |=> (count_i == '0));

  p_oneshot_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_c_i && stop_c_i && !en_cmd_i) |=> !run_i);

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpcs_i && !stat_rd_i) |=> cpcs_i);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_c_i |=> cpcs_i);

  p_wave_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_c_i && act_c_i == ACT_SET) |=> wave_i);

  p_wave_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_c_i && act_c_i == ACT_CLR) |=> !wave_i);

  p_sync_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (count_i == '0));
endmodule

bind cmt_channel cmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .trg_i     (trg_cmd),
  .en_cmd_i  (en_cmd),
  .run_i     (run),
  .tick_i    (tick),
  .match_c_i (match_c),
  .auto_rst_i(auto_rst),
  .stop_c_i  (stop_c),
  .act_c_i   (act_c),
  .count_i   (count),
  .cmp_c_i   (cmp_c_q),
  .stat_rd_i (stat_rd),
  .cpcs_i    (cpcs_q),
  .wave_i    (wave_o)
);

// File: tb/sim_cmt_channel.sv
`timescale 1ns/1ps
module sim_cmt_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en0 = 1'b0, wr_en1 = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata0, rdata1;
  logic        slow = 1'b0, ext = 1'b0, sync = 1'b0;
  logic        wave0, wave1, irq0, irq1;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmt_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en0), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0),
    .slow_tick_i(slow), .ext_clk_i(ext), .sync_i(sync),
    .wave_o(wave0), .irq_o(irq0)
  );

  cmt_channel u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en1), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1),
    .slow_tick_i(slow), .ext_clk_i(wave0), .sync_i(sync),
    .wave_o(wave1), .irq_o(irq1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] md(input int src, input bit ar, input bit st,
                                     input logic [1:0] aa, input logic [1:0] ac);
    return {7'b0, ac, aa, st, ar, 3'(src)};
  endfunction

  task automatic wr(input bit ch, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (ch) wr_en1 = 1'b1; else wr_en0 = 1'b1;
    @(negedge clk);
    wr_en0 = 1'b0; wr_en1 = 1'b0;
  endtask

  task automatic rd(input bit ch, input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = ch ? rdata1 : rdata0;
  endtask

  task automatic rd_stat(output logic [15:0] d);
    @(negedge clk);
    addr = 3'd5; rd_en = 1'b1;
    #1 d = rdata0;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    slow = 1'b1;
    repeat (n) @(negedge clk);
    slow = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, 3'd2, v); chk("R1 count", v, 0);
    rd(0, 3'd1, v); chk("R1 mode", v, 0);
    rd(0, 3'd5, v); chk("R1 status", v, 0);
    chk("R1 wave", wave0, 0);
    chk("R1 irq", irq0, 0);
    wr(0, 3'd1, md(4, 0, 0, 0, 0));
    ticks(3);
    rd(0, 3'd2, v); chk("R1 idle count", v, 0);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr(0, 3'd3, 16'h1234); rd(0, 3'd3, v); chk("R13 cmpa", v, 16'h1234);
    wr(0, 3'd4, 16'hBEEF); rd(0, 3'd4, v); chk("R13 cmpc", v, 16'hBEEF);
    wr(0, 3'd1, 16'h01AC); rd(0, 3'd1, v); chk("R13 mode", v, 16'h01AC);
  endtask

  task automatic t_cmd();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 0, 0, 0, 0));
    wr(0, 3'd4, 16'hFFFF);
    wr(0, 3'd0, 16'h5);
    ticks(5); rd(0, 3'd2, v); chk("R2 run", v, 5);
    wr(0, 3'd0, 16'h3);
    ticks(3); rd(0, 3'd2, v); chk("R2 off wins", v, 5);
    wr(0, 3'd0, 16'h4);
    rd(0, 3'd2, v); chk("R2 restart idle", v, 0);
    ticks(2); rd(0, 3'd2, v); chk("R2 still idle", v, 0);
    wr(0, 3'd0, 16'h1);
    ticks(4); rd(0, 3'd2, v); chk("R2 on", v, 4);
  endtask

  task automatic t_freerun();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 0, 0, 0, 0));
    wr(0, 3'd0, 16'h5);
    ticks(65535); rd(0, 3'd2, v); chk("R3 top", v, 16'hFFFF);
    ticks(1);     rd(0, 3'd2, v); chk("R3 wrap", v, 0);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 1, 0, 0, 0));
    wr(0, 3'd4, 16'd3);
    rd_stat(v);
    wr(0, 3'd0, 16'h5);
    ticks(3); rd(0, 3'd2, v); chk("R4 at C", v, 3);
    rd_stat(v); chk("R4 no flag yet", v, 0);
    ticks(1); rd(0, 3'd2, v); chk("R4 reload", v, 0);
    rd_stat(v); chk("R4 flag", v, 1);
    ticks(5); rd(0, 3'd2, v); chk("R4 period", v, 1);
  endtask

  task automatic t_oneshot();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 1, 1, 0, 0));
    wr(0, 3'd4, 16'd2);
    rd_stat(v);
    wr(0, 3'd6, 16'h1);
    wr(0, 3'd0, 16'h5);
    ticks(3); rd(0, 3'd2, v); chk("R5 fired", v, 0);
    chk("R7 irq on", irq0, 1);
    ticks(4); rd(0, 3'd2, v); chk("R5 halted", v, 0);
    wr(0, 3'd0, 16'h5);
    ticks(1); rd(0, 3'd2, v); chk("R5 rearm", v, 1);
  endtask

  task automatic t_status();
    logic [15:0] v;
    rd_stat(v); chk("R6 sticky", v, 1);
    rd_stat(v); chk("R6 cleared", v, 0);
    chk("R7 irq off", irq0, 0);
    wr(0, 3'd1, md(4, 1, 0, 0, 0));
    wr(0, 3'd4, 16'd1);
    wr(0, 3'd0, 16'h5);
    ticks(1);
    @(negedge clk);
    slow = 1'b1; addr = 3'd5; rd_en = 1'b1;
    #1 chk("R6 pre-read", rdata0, 0);
    @(negedge clk);
    slow = 1'b0; rd_en = 1'b0;
    rd(0, 3'd5, v); chk("R6 set wins", v, 1);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    chk("R7 irq", irq0, 1);
    wr(0, 3'd7, 16'hFF); chk("R7 masked", irq0, 0);
    wr(0, 3'd6, 16'h1);  chk("R7 unmasked", irq0, 1);
    rd_stat(v);
    @(negedge clk); chk("R7 flag read", irq0, 0);
  endtask

  task automatic t_wave();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 1, 0, 1, 2));
    wr(0, 3'd3, 16'd0);
    wr(0, 3'd4, 16'd5);
    wr(0, 3'd0, 16'h5);
    ticks(1); @(negedge clk); chk("R8 A set", wave0, 1);
    wr(0, 3'd3, 16'd5);
    ticks(5); @(negedge clk); chk("R8 C wins", wave0, 0);
    rd(0, 3'd2, v); chk("R8 count", v, 0);
  endtask

  task automatic t_duty_cascade();
    logic [15:0] a, b;
    int hi = 0;
    wr(0, 3'd1, md(0, 1, 0, 1, 2));
    wr(0, 3'd3, 16'd1);
    wr(0, 3'd4, 16'd3);
    wr(1, 3'd1, md(5, 0, 0, 0, 0));
    wr(1, 3'd4, 16'hFFFF);
    wr(1, 3'd0, 16'h5);
    wr(0, 3'd0, 16'h5);
    repeat (32) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (wave0) hi++;
    end
    chk("R8 duty", hi, 128);
    rd(1, 3'd2, a);
    repeat (255) @(negedge clk);
    rd(1, 3'd2, b);
    chk("R10 cascade", 32'(b - a), 32);
  endtask

  task automatic t_rates();
    logic [15:0] a, b;
    int exp_d [3] = '{64, 16, 0};
    int code  [3] = '{0, 1, 6};
    for (int k = 0; k < 3; k++) begin
      wr(0, 3'd1, md(code[k], 0, 0, 0, 0));
      wr(0, 3'd4, 16'hFFFF);
      wr(0, 3'd0, 16'h5);
      rd(0, 3'd2, a);
      repeat (127) @(negedge clk);
      rd(0, 3'd2, b);
      chk($sformatf("R9 rate code %0d", code[k]), 32'(b - a), exp_d[k]);
    end
  endtask

  task automatic t_ext();
    logic [15:0] v;
    wr(0, 3'd1, md(5, 0, 0, 0, 0));
    wr(0, 3'd0, 16'h5);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); ext = 1'b1;
      repeat (20) @(negedge clk);
      ext = 1'b0;
      repeat (20) @(negedge clk);
    end
    rd(0, 3'd2, v); chk("R10 edges", v, 2);
  endtask

  task automatic t_sync();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 0, 0, 0, 0));
    wr(0, 3'd0, 16'h5);
    ticks(4); rd(0, 3'd2, v); chk("R11 before", v, 4);
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    rd(0, 3'd2, v); chk("R11 zeroed", v, 0);
    ticks(2); rd(0, 3'd2, v); chk("R11 keeps running", v, 2);
  endtask

  task automatic t_cwrite();
    logic [15:0] v;
    wr(0, 3'd1, md(4, 1, 0, 0, 0));
    wr(0, 3'd4, 16'd10);
    wr(0, 3'd0, 16'h5);
    ticks(5);
    rd_stat(v);
    wr(0, 3'd4, 16'd3);
    ticks(10); rd(0, 3'd2, v); chk("R12 passed C", v, 15);
    rd_stat(v); chk("R12 no event", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_cmd();
    t_freerun();
    t_reload();
    t_oneshot();
    t_status();
    t_irq();
    t_wave();
    t_duty_cascade();
    t_rates();
    t_ext();
    t_sync();
    t_cwrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule